// File: doc/BRIEF.md
# Stereo Audio De-Emphasis Shelf Filter

This block removes the treble boost that some recordings carry as a noise-reduction measure (a 50 µs / 15 µs pre-emphasis). It is a first-order digital shelf: flat at 0 dB for low frequencies, with the response starting to fall near 3.2 kHz and levelling off about 10 dB down above roughly 10.6 kHz. The coefficients are fixed for a 44.1 kHz sample rate. At any other rate the corners move in proportion to that rate.

Left and right 24-bit signed samples arrive one at a time on a single port. Each carries a channel tag and a valid strobe. One multiply-accumulate path serves both channels, and each channel keeps its own one-sample history. Filtering is active only when the enable input is high and the converter reports single-speed operation. In every other case the samples pass through unchanged. The mode is decided on each left sample and held for the right sample that follows. When the mode changes, the history of both channels is wiped, so that stale data does not cause a click.

Top module: `deemph_filter`

## Requirements
- R1: While filtering, each channel computes y = (1800992·x + (−250418)·x1 + 2643730·y1) / 2^22. Here x1 and y1 are the previous input and output of that same channel, and the constants are signed Q2.22 values from a bilinear mapping of a 15 µs zero and a 50 µs pole at 44.1 kHz.
- R2: The sum is rounded to nearest by adding 2^21 and then shifting right arithmetically by 22. The result is clamped to the range −8388608 to 8388607.
- R3: Unity gain at DC: a constant input held long enough produces an output within 1 LSB of that input.
- R4: High-frequency shelf: an input that alternates ±A every sample on one channel settles to an output amplitude between 0.295·A and 0.305·A (about −10.5 dB).
- R5: If enable is 0 or single-speed is 0 on a left sample, that sample is output bit-exact and unfiltered.
- R6: The channel tag is 0 for left and 1 for right. A right sample uses the mode latched by the most recent left sample, and its own enable and single-speed inputs are ignored.
- R7: The channels keep separate history, so activity on one channel never changes the outputs of the other.
- R8: When a left sample brings a mode different from the latched one, both channels' histories are zeroed before that sample is computed.
- R9: out_valid pulses exactly 2 clocks after each in_valid, with out_ch equal to that sample's tag. It never pulses at any other time.
- R10: After reset, out_valid and out_data are 0 and the latched mode is bypass. out_data holds its value between output strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (released synchronously inside) |
| in_valid | input | 1 | Input sample strobe |
| in_ch | input | 1 | Channel tag: 0 left, 1 right |
| in_data | input | 24 | Signed input sample |
| deemph_en | input | 1 | De-emphasis enable, sampled on left samples |
| single_speed | input | 1 | High when the converter runs in single-speed mode, sampled on left samples |
| out_valid | output | 1 | Output sample strobe |
| out_ch | output | 1 | Channel tag of the output sample |
| out_data | output | 24 | Signed filtered or bypassed sample |

## Verification
Some properties are checked on every cycle by assertions: the fixed two-clock latency and the echoed tag, the absence of stray output strobes, exact pass-through of bypassed left samples, output holding between strobes, and zeroed history after any bypassed left sample. Other behaviour can only be shown by the bench scenarios. These are the numeric filter response against a bit-exact scoreboard model, unity DC gain, the −10 dB shelf under alternating input, the separation of the two channels, the mode latch that ignores the right sample's controls, and the output after a mode change, which comes from a cleared history.

// File: rtl/deemph_pkg.sv
package deemph_pkg;
  localparam int COEF_W = 24;
  localparam int FRAC_W = 22;
  // Q2.22 coefficients: zero 15 us, pole 50 us, bilinear at 44.1 kHz
  localparam logic signed [COEF_W-1:0] C_FWD0 = 24'sd1800992;
  localparam logic signed [COEF_W-1:0] C_FWD1 = -24'sd250418;
  localparam logic signed [COEF_W-1:0] C_BACK = 24'sd2643730;

  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
endpackage

// File: rtl/deemph_ctrl.sv
module deemph_ctrl
  import deemph_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_ch,
  input  logic [DW-1:0] in_data,
  input  logic          en,
  input  logic          ss,
  output logic          s1_valid,
  output logic          s1_ch,
  output logic [DW-1:0] s1_x,
  output logic          s1_act,
  output logic          s1_clr
);
  logic mode_q, mode_d;
  logic act_d, clr_d, want;

  always_comb begin
    want   = en & ss;
    mode_d = mode_q;
    act_d  = mode_q;
    clr_d  = 1'b0;
    if (in_valid && (in_ch == CH_LEFT)) begin
      mode_d = want;
      act_d  = want;
      clr_d  = (want != mode_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      s1_valid <= 1'b0;
      s1_ch    <= 1'b0;
      s1_x     <= '0;
      s1_act   <= 1'b0;
      s1_clr   <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_ch  <= in_ch;
        s1_x   <= in_data;
        s1_act <= act_d;
        s1_clr <= clr_d;
      end
    end
  end
endmodule

// File: rtl/deemph_state.sv
module deemph_state #(
  parameter int DW  = 24,
  parameter int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CHW-1:0]    wr_sel,
  input  logic [DW-1:0]     wr_x,
  input  logic [DW-1:0]     wr_y,
  input  logic              clr,
  output logic [NCH*DW-1:0] x1_flat,
  output logic [NCH*DW-1:0] y1_flat
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] x_q, y_q, x_d, y_d;
    logic          ld;

    always_comb begin
      ld  = 1'b0;
      x_d = x_q;
      y_d = y_q;
      if (wr_en && (wr_sel == CHW'(i))) begin
        ld  = 1'b1;
        x_d = wr_x;
        y_d = wr_y;
      end else if (clr) begin
        ld  = 1'b1;
        x_d = '0;
        y_d = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x_q <= '0;
        y_q <= '0;
      end else if (ld) begin
        x_q <= x_d;
        y_q <= y_d;
      end
    end

    assign x1_flat[i*DW +: DW] = x_q;
    assign y1_flat[i*DW +: DW] = y_q;
  end
endmodule

// File: rtl/deemph_mac.sv
module deemph_mac
  import deemph_pkg::*;
#(
  parameter int DW = 24,
  parameter int CW = COEF_W,
  parameter int FW = FRAC_W,
  parameter logic signed [CW-1:0] K0 = C_FWD0,
  parameter logic signed [CW-1:0] K1 = C_FWD1,
  parameter logic signed [CW-1:0] KB = C_BACK,
  localparam int AW = DW + CW + 2
) (
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] x1,
  input  logic signed [DW-1:0] y1,
  output logic signed [DW-1:0] y
);
  localparam logic signed [AW-1:0] HALF = AW'(1) << (FW - 1);
  localparam logic signed [AW-1:0] VMAX = (AW'(1) << (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] VMIN = -VMAX - AW'(1);

  logic signed [AW-1:0] acc, sh;

  always_comb begin
    acc = AW'(x) * AW'(K0) + AW'(x1) * AW'(K1) + AW'(y1) * AW'(KB);
    sh  = (acc + HALF) >>> FW;
    if (sh > VMAX)      y = VMAX[DW-1:0];
    else if (sh < VMIN) y = VMIN[DW-1:0];
    else                y = sh[DW-1:0];
  end
endmodule

// File: rtl/deemph_filter.sv
module deemph_filter
  import deemph_pkg::*;
#(
  parameter int DW  = 24,
  parameter int NCH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_ch,
  input  logic [DW-1:0] in_data,
  input  logic          deemph_en,
  input  logic          single_speed,
  output logic          out_valid,
  output logic          out_ch,
  output logic [DW-1:0] out_data
);
  logic [1:0]          rst_pipe;
  logic                rst_sync_n;
  logic                s1_valid, s1_ch, s1_act, s1_clr;
  logic [DW-1:0]       s1_x;
  logic [NCH*DW-1:0]   x1_flat, y1_flat;
  logic signed [DW-1:0] hx1, hy1, y_calc;
  logic                vld_d, ch_d;
  logic [DW-1:0]       dat_d;

  // async assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  deemph_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_ch(in_ch),
    .in_data(in_data), .en(deemph_en), .ss(single_speed),
    .s1_valid(s1_valid), .s1_ch(s1_ch), .s1_x(s1_x),
    .s1_act(s1_act), .s1_clr(s1_clr)
  );

  deemph_state #(.DW(DW), .NCH(NCH)) u_state (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(s1_valid & s1_act), .wr_sel(s1_ch),
    .wr_x(s1_x), .wr_y(y_calc),
    .clr(s1_valid & s1_clr),
    .x1_flat(x1_flat), .y1_flat(y1_flat)
  );

  always_comb begin
    hx1 = x1_flat[int'(s1_ch)*DW +: DW];
    hy1 = y1_flat[int'(s1_ch)*DW +: DW];
    if (s1_clr) begin
      hx1 = '0;
      hy1 = '0;
    end
  end

  deemph_mac #(.DW(DW)) u_mac (
    .x(s1_x), .x1(hx1), .y1(hy1), .y(y_calc)
  );

  always_comb begin
    vld_d = s1_valid;
    ch_d  = out_ch;
    dat_d = out_data;
    if (s1_valid) begin
      ch_d  = s1_ch;
      dat_d = s1_act ? y_calc : s1_x;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_ch    <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= vld_d;
      if (s1_valid) begin
        out_ch   <= ch_d;
        out_data <= dat_d;
      end
    end
  end
endmodule

// File: rtl/deemph_filter_chk.sv
module deemph_filter_chk #(
  parameter int DW  = 24,
  parameter int NCH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ch,
  input logic [DW-1:0]     in_data,
  input logic              deemph_en,
  input logic              single_speed,
  input logic              out_valid,
  input logic              out_ch,
  input logic [DW-1:0]     out_data,
  input logic [NCH*DW-1:0] x1_flat,
  input logic [NCH*DW-1:0] y1_flat
);
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 (out_valid && (out_ch == $past(in_ch, 2))));

  p_no_stray_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  p_bypass_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ch && !(deemph_en && single_speed))
      |=> ##1 (out_data == $past(in_data, 2)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ch && $past(!(deemph_en && single_speed), 2))
      |-> ((x1_flat == '0) && (y1_flat == '0)));
endmodule

bind deemph_filter deemph_filter_chk #(.DW(DW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_ch(in_ch),
  .in_data(in_data), .deemph_en(deemph_en), .single_speed(single_speed),
  .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data),
  .x1_flat(x1_flat), .y1_flat(y1_flat)
);

// File: tb/deemph_filter_tb.sv
module deemph_filter_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit     ch;
    int     data;
    longint due;
    string  tag;
  } exp_t;

  logic clk, rst_n, in_valid, in_ch, deemph_en, single_speed;
  logic signed [23:0] in_data;
  logic out_valid, out_ch;
  logic signed [23:0] out_data;

  exp_t   sb[$];
  longint cyc;
  int     n_cmp, n_bad;
  bit     mon_on;
  int     last_out[2];

  longint m_x1[2], m_y1[2];
  bit     m_act;

  deemph_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch),
    .in_data(in_data), .deemph_en(deemph_en), .single_speed(single_speed),
    .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // R1/R2 reference arithmetic
  function automatic int calc(longint x, longint x1, longint y1);
    longint a;
    a = x * 1800992 + x1 * (-250418) + y1 * 2643730;
    a = (a + 2097152) >>> 22;
    if (a > 8388607) a = 8388607;
    if (a < -8388608) a = -8388608;
    return int'(a);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(bit ch, int x, bit en, bit ss, string tag);
    exp_t e;
    bit   act;
    int   y;
    @(negedge clk);
    in_valid     = 1'b1;
    in_ch        = ch;
    in_data      = x[23:0];
    deemph_en    = en;
    single_speed = ss;
    if (ch == 1'b0) begin
      act = en & ss;
      if (act != m_act) begin
        m_x1 = '{0, 0};
        m_y1 = '{0, 0};
      end
      m_act = act;
    end
    if (m_act) begin
      y = calc(x, m_x1[ch], m_y1[ch]);
      m_x1[ch] = x;
      m_y1[ch] = y;
    end else begin
      y = x;
    end
    e.ch = ch; e.data = y; e.due = cyc + 2; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9 stray out_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_data == e.data[23:0], {e.tag, " data"}, out_data, e.data);
          check(out_ch == e.ch, "R9 out_ch", out_ch, e.ch);
          check(cyc == e.due, "R9 latency", cyc, e.due);
          last_out[out_ch] = int'(out_data);
        end
      end else if (sb.size() != 0 && sb[0].due < cyc) begin
        check(1'b0, "R9 missing output", 0, 1);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int hold;
    n_cmp = 0; n_bad = 0; mon_on = 1'b0;
    m_act = 1'b0; m_x1 = '{0, 0}; m_y1 = '{0, 0};
    last_out = '{0, 0};
    in_valid = 1'b0; in_ch = 1'b0; in_data = '0;
    deemph_en = 1'b0; single_speed = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R10 reset out_valid", out_valid, 0);
    check(out_data == 24'sd0, "R10 reset out_data", out_data, 0);
    mon_on = 1'b1;

    // R5 bypass, enable low
    send(0, 123456, 0, 1, "R5 en low L");
    send(1, -7654321, 0, 1, "R5 en low R");
    send(0, 8388607, 0, 1, "R5 en low L max");
    send(1, -8388608, 0, 1, "R5 en low R min");
    // R5 bypass, not single-speed
    send(0, -42, 1, 0, "R5 not ss L");
    repeat (3) @(negedge clk);
    send(1, 999, 1, 0, "R5 not ss R");
    drain();

    // R1/R7 impulse on left, silence on right
    send(0, 4194304, 1, 1, "R1 impulse L");
    send(1, 0, 1, 1, "R7 quiet R");
    drain();
    check(last_out[0] == 1800992, "R1 first impulse tap", last_out[0], 1800992);
    for (int i = 0; i < 6; i++) begin
      send(0, 0, 1, 1, "R1 impulse tail L");
      send(1, 0, 1, 1, "R7 quiet R");
    end
    drain();
    check(last_out[1] == 0, "R7 right untouched", last_out[1], 0);

    // R2 full-scale stress
    for (int i = 0; i < 20; i++) begin
      send(0, (i % 2 == 0) ? 8388607 : -8388608, 1, 1, "R2 fullscale L");
      send(1, -8388608, 1, 1, "R2 fullscale R");
      if (i % 5 == 0) repeat (2) @(negedge clk);
    end
    drain();

    // R3 DC gain
    for (int i = 0; i < 60; i++) begin
      send(0, 1000000, 1, 1, "R3 dc L");
      send(1, -3000000, 1, 1, "R3 dc R");
    end
    drain();
    check((last_out[0] >= 999999) && (last_out[0] <= 1000001), "R3 dc L settle",
          last_out[0], 1000000);
    check((last_out[1] >= -3000001) && (last_out[1] <= -2999999), "R3 dc R settle",
          last_out[1], -3000000);

    // R4 Nyquist shelf
    for (int i = 0; i < 80; i++) begin
      send(0, (i % 2 == 0) ? 4000000 : -4000000, 1, 1, "R4 nyq L");
      send(1, 0, 1, 1, "R7 zero R");
    end
    drain();
    begin
      int mag;
      mag = (last_out[0] < 0) ? -last_out[0] : last_out[0];
      check((mag >= 1180000) && (mag <= 1220000), "R4 shelf amplitude", mag, 1200000);
    end

    // R8 clear on mode change, R6 right ignores its own controls
    send(0, 555555, 0, 1, "R8 bypass L");
    send(1, 777777, 1, 1, "R6 right follows latched bypass");
    drain();
    check(last_out[1] == 777777, "R6 right bypassed despite en", last_out[1], 777777);
    send(0, 4194304, 1, 1, "R8 reenable L");
    send(1, 4194304, 0, 0, "R6 right filtered despite en low");
    drain();
    check(last_out[0] == 1800992, "R8 left from cleared history", last_out[0], 1800992);
    check(last_out[1] == 1800992, "R6 R8 right from cleared history", last_out[1], 1800992);

    // R10 hold between strobes
    hold = last_out[1];
    repeat (6) @(negedge clk);
    check(out_valid == 1'b0, "R10 idle strobe", out_valid, 0);
    check(int'(out_data) == hold, "R10 data hold", out_data, hold);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule